// File: doc/BRIEF.md
# Pooled Spreading-Code Link Arbiter

This block controls a shared code-division link that fourteen nodes use. Any node may ask to send to any other node. It does this by raising a request and giving a destination number. Nodes do not own fixed spreading codes. The arbiter keeps a pool of seven Walsh code numbers and lends one to each transfer it admits. It takes the code back when the sender signals that it has finished. The arbiter therefore decides who may transmit, to whom, and with which code. The data path that does the encoding and decoding sits outside this block.

In every cycle the arbiter looks at all pending requests together. A request is admitted when all three of these hold:

- the receiver is idle;
- no more important node is asking for the same receiver;
- enough free codes remain after reserving one for each more important request.

Priority is static, and a lower node index wins. Once a request is admitted, the sender sees an encode enable and a code number one clock later. In the same cycle the receiver sees a decode grant carrying the same code number. A one-cycle ready pulse from the sender ends the link and returns both the code and the receiver to the pool.

Top module: `cdma_code_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every encode enable, decode grant and code number output is zero.
- R2: A request from an idle node to an idle receiver, with a free code available, raises that node's encode enable one clock edge after the request is sampled. The receiver's decode grant rises at the same edge.
- R3: When several idle nodes ask for the same idle receiver in one cycle, only the lowest-numbered of them is granted.
- R4: A request aimed at a receiver whose decode grant is high is not granted. This includes the cycle in which that receiver's current sender pulses ready.
- R5: Node i is granted only if 7 − (codes in use) − (eligible requests from nodes below i) ≥ 1. As a result, never more than 7 links are active.
- R6: Code numbers run from 0 to 6. The free codes are taken in ascending order. A granted node receives the free code whose position in that order equals the number of lower-numbered nodes granted in the same cycle.
- R7: A ready pulse from an active sender clears, at the next edge, the sender's enable and code, the receiver's decode grant and code, and the code's reservation. The code can then be granted again.
- R8: A node whose encode enable is high is left out of arbitration. Its code stays unchanged until its ready pulse.
- R9: A request whose destination number is 14 or above is ignored.
- R10: The code number shown at a receiver equals the code number shown at its sender. No two active links share a code or a receiver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 14 | Per-node transfer request |
| req_dest | input | 56 | Per-node destination, 4 bits per node, node k at bits 4k+3:4k |
| ready | input | 14 | Per-node end-of-transfer pulse |
| enc_en | output | 14 | Per-sender encode enable |
| enc_code | output | 42 | Per-sender code number, 3 bits per node, node k at bits 3k+2:3k |
| dec_grant | output | 14 | Per-receiver decode grant |
| dec_code | output | 42 | Per-receiver code number, same packing as enc_code |

## Verification
The bench uses the default build: fourteen nodes, seven codes, 4-bit destinations and 3-bit code numbers. At these values the code pool is smaller than the node count. This lets the bench fill all seven codes with seven concurrent links and then show that an eighth request is held back. It can also free one code in the middle of the pool and see it re-issued. With 4-bit destinations, the numbers 14 and 15 can be driven, so the invalid-destination path is also exercised.

// File: rtl/cdma_alloc_pkg.sv
package cdma_alloc_pkg;

   // number of set bits in a vector of up to 64 bits
   function automatic int ones(input logic [63:0] v);
      int n;
      n = 0;
      for (int k = 0; k < 64; k++) n += int'(v[k]);
      return n;
   endfunction

endpackage

// File: rtl/alloc_request_filter.sv
module alloc_request_filter #(
   parameter int N_NODES = 14,
   parameter int N_CODES = 7,
   parameter int AW      = 4,
   parameter int CNTW    = 3
) (
   input  logic [N_NODES-1:0]    req,
   input  logic [N_NODES*AW-1:0] req_dest,
   input  logic [N_NODES-1:0]    active,
   input  logic [N_NODES-1:0]    busy,
   input  logic [CNTW-1:0]       used_cnt,
   output logic [N_NODES-1:0]    grant
);
   localparam int BW = 1 << AW;

   if (N_NODES > BW) begin : g_bad_aw
      $error("destination width too small for node count");
   end

   logic [BW-1:0]      busy_ext;
   logic [N_NODES-1:0] elig;

   assign busy_ext = BW'(busy);

   // a request is eligible when its node is idle and its receiver is real and free
   for (genvar i = 0; i < N_NODES; i++) begin : g_elig
      logic [AW-1:0] d;
      assign d       = req_dest[i*AW +: AW];
      assign elig[i] = req[i] & ~active[i] & (int'(d) < N_NODES) & ~busy_ext[d];
   end

   for (genvar i = 0; i < N_NODES; i++) begin : g_grant
      always_comb begin
         int   higher;
         logic clash;
         higher = 0;
         clash  = 1'b0;
         for (int j = 0; j < i; j++) begin
            if (elig[j]) begin
               higher += 1;
               if (req_dest[j*AW +: AW] == req_dest[i*AW +: AW]) clash = 1'b1;
            end
         end
         grant[i] = elig[i] & ~clash & ((N_CODES - int'(used_cnt) - higher) >= 1);
      end
   end

endmodule

// File: rtl/alloc_code_select.sv
module alloc_code_select #(
   parameter int N_NODES = 14,
   parameter int N_CODES = 7,
   parameter int CDW     = 3
) (
   input  logic [N_NODES-1:0]     grant,
   input  logic [N_CODES-1:0]     in_use,
   output logic [N_NODES*CDW-1:0] pick
);
   if ((1 << CDW) < N_CODES) begin : g_bad_cdw
      $error("code number width too small for pool size");
   end

   // rank of node i among this cycle's grants selects the rank-th free code
   for (genvar i = 0; i < N_NODES; i++) begin : g_pick
      always_comb begin
         int             rank;
         int             seen;
         logic           found;
         logic [CDW-1:0] c_sel;
         rank  = 0;
         seen  = 0;
         found = 1'b0;
         c_sel = '0;
         for (int j = 0; j < i; j++) rank += int'(grant[j]);
         for (int c = 0; c < N_CODES; c++) begin
            if (!in_use[c] && !found) begin
               if (seen == rank) begin
                  c_sel = CDW'(c);
                  found = 1'b1;
               end
               seen += 1;
            end
         end
         pick[i*CDW +: CDW] = c_sel;
      end
   end

endmodule

// File: rtl/cdma_code_arbiter.sv
module cdma_code_arbiter #(
   parameter int N_NODES = 14,
   parameter int N_CODES = 7,
   parameter int AW      = 4,
   parameter int CDW     = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_NODES-1:0]     req,
   input  logic [N_NODES*AW-1:0]  req_dest,
   input  logic [N_NODES-1:0]     ready,
   output logic [N_NODES-1:0]     enc_en,
   output logic [N_NODES*CDW-1:0] enc_code,
   output logic [N_NODES-1:0]     dec_grant,
   output logic [N_NODES*CDW-1:0] dec_code
);
   import cdma_alloc_pkg::*;

   localparam int CNTW = $clog2(N_CODES + 1);

   if (N_NODES < 2 || N_NODES > 64)       begin : g_bad_n  $error("node count out of range"); end
   if (N_CODES < 1 || N_CODES > 64)       begin : g_bad_c  $error("code count out of range"); end
   if (AW < $clog2(N_NODES))              begin : g_bad_aw $error("AW too narrow"); end
   if (CDW < $clog2(N_CODES))             begin : g_bad_cw $error("CDW too narrow"); end

   logic [N_NODES-1:0]     link_q;
   logic [CDW-1:0]         scode_q [N_NODES];
   logic [AW-1:0]          sdest_q [N_NODES];
   logic [N_NODES-1:0]     rbusy_q;
   logic [CDW-1:0]         rcode_q [N_NODES];
   logic [N_CODES-1:0]     inuse_q;
   logic [CNTW-1:0]        used_cnt;
   logic [N_NODES-1:0]     grant;
   logic [N_NODES*CDW-1:0] pick;

   assign used_cnt = CNTW'(ones(64'(inuse_q)));

   alloc_request_filter #(
      .N_NODES(N_NODES), .N_CODES(N_CODES), .AW(AW), .CNTW(CNTW)
   ) u_filter (
      .req(req), .req_dest(req_dest), .active(link_q), .busy(rbusy_q),
      .used_cnt(used_cnt), .grant(grant)
   );

   alloc_code_select #(
      .N_NODES(N_NODES), .N_CODES(N_CODES), .CDW(CDW)
   ) u_select (
      .grant(grant), .in_use(inuse_q), .pick(pick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         link_q  <= '0;
         rbusy_q <= '0;
         inuse_q <= '0;
         for (int i = 0; i < N_NODES; i++) begin
            scode_q[i] <= '0;
            sdest_q[i] <= '0;
            rcode_q[i] <= '0;
         end
      end else begin
         // releases use the held state, so they cannot touch a bit granted below
         for (int i = 0; i < N_NODES; i++) begin
            if (link_q[i] && ready[i]) begin
               link_q[i]                          <= 1'b0;
               scode_q[i]                         <= '0;
               rbusy_q[sdest_q[i]]                <= 1'b0;
               rcode_q[sdest_q[i]]                <= '0;
               inuse_q[scode_q[i]]                <= 1'b0;
            end
         end
         for (int i = 0; i < N_NODES; i++) begin
            if (grant[i]) begin
               link_q[i]                          <= 1'b1;
               scode_q[i]                         <= pick[i*CDW +: CDW];
               sdest_q[i]                         <= req_dest[i*AW +: AW];
               rbusy_q[req_dest[i*AW +: AW]]      <= 1'b1;
               rcode_q[req_dest[i*AW +: AW]]      <= pick[i*CDW +: CDW];
               inuse_q[pick[i*CDW +: CDW]]        <= 1'b1;
            end
         end
      end
   end

   assign enc_en    = link_q;
   assign dec_grant = rbusy_q;

   for (genvar i = 0; i < N_NODES; i++) begin : g_out
      assign enc_code[i*CDW +: CDW] = scode_q[i];
      assign dec_code[i*CDW +: CDW] = rcode_q[i];

      assert_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
         grant[i] |=> link_q[i]);
      assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
         link_q[i] && ready[i] |=> !link_q[i]);
      assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         link_q[i] && !ready[i] |=> link_q[i] && $stable(scode_q[i]));
      assert_code_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
         grant[i] |-> !inuse_q[pick[i*CDW +: CDW]]);
   end

   assert_code_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(link_q) <= N_CODES);
   assert_pairing_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(link_q) == $countones(inuse_q)) && ($countones(link_q) == $countones(rbusy_q)));

endmodule

// File: tb/test_cdma_code_arbiter.sv
module test_cdma_code_arbiter;
   localparam int N  = 14;
   localparam int AW = 4;
   localparam int CW = 3;
   localparam int NV = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    req = '0;
   logic [N*AW-1:0] req_dest = '0;
   logic [N-1:0]    ready = '0;
   logic [N-1:0]    enc_en;
   logic [N*CW-1:0] enc_code;
   logic [N-1:0]    dec_grant;
   logic [N*CW-1:0] dec_code;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cdma_code_arbiter i_cdma_code_arbiter (
      .clk(clk), .rst_n(rst_n), .req(req), .req_dest(req_dest), .ready(ready),
      .enc_en(enc_en), .enc_code(enc_code), .dec_grant(dec_grant), .dec_code(dec_code)
   );

   function automatic logic [N*AW-1:0] dp(input int node, input int dest);
      return (N*AW)'(dest) << (node*AW);
   endfunction

   // stimulus vectors: request mask, destinations, ready mask, expected enables, expected grants
   localparam logic [N-1:0]    V_REQ  [NV] = '{14'h0007, 14'h0002, 14'h0002, 14'h0002, 14'h000C, 14'h0000};
   localparam logic [N*AW-1:0] V_DEST [NV] = '{dp(0,5)|dp(1,5)|dp(2,6), dp(1,5), dp(1,5), dp(1,5),
                                               dp(3,15)|dp(2,7), '0};
   localparam logic [N-1:0]    V_RDY  [NV] = '{14'h0000, 14'h0000, 14'h0001, 14'h0000, 14'h0000, 14'h0006};
   localparam logic [N-1:0]    V_ENC  [NV] = '{14'h0005, 14'h0005, 14'h0004, 14'h0006, 14'h0006, 14'h0000};
   localparam logic [N-1:0]    V_BUSY [NV] = '{14'h0060, 14'h0060, 14'h0040, 14'h0060, 14'h0060, 14'h0000};

   function automatic string vtag(input int k);
      case (k)
         0: return "R2/R3";
         1: return "R4";
         2: return "R7 and R4";
         3: return "R6";
         4: return "R8 and R9";
         default: return "R7";
      endcase
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [CW-1:0] ecode(input int k);
      return enc_code[k*CW +: CW];
   endfunction
   function automatic logic [CW-1:0] dcode(input int k);
      return dec_code[k*CW +: CW];
   endfunction

   // apply one cycle of stimulus and sample at the following falling edge
   task automatic step(input logic [N-1:0] r, input logic [N*AW-1:0] d, input logic [N-1:0] y);
      req = r; req_dest = d; ready = y;
      @(posedge clk);
      @(negedge clk);
      req = '0; req_dest = '0; ready = '0;
   endtask

   initial begin
      @(negedge clk);
      check("R1 reset enables", 64'(enc_en), 64'(0));
      check("R1 reset grants", 64'(dec_grant), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset codes", 64'(enc_code | dec_code), 64'(0));

      for (int k = 0; k < NV; k++) begin
         step(V_REQ[k], V_DEST[k], V_RDY[k]);
         check({vtag(k), " enables"}, 64'(enc_en), 64'(V_ENC[k]));
         check({vtag(k), " receivers"}, 64'(dec_grant), 64'(V_BUSY[k]));
         if (k == 0) begin
            check("R6 node0 code", 64'(ecode(0)), 64'(0));
            check("R6 node2 code", 64'(ecode(2)), 64'(1));
            check("R10 rx5 code", 64'(dcode(5)), 64'(ecode(0)));
            check("R10 rx6 code", 64'(dcode(6)), 64'(ecode(2)));
         end
         if (k == 3) check("R6 reused code0", 64'(ecode(1)), 64'(0));
         if (k == 5) check("R7 codes cleared", 64'(enc_code | dec_code), 64'(0));
      end

      // fill the pool: nodes 0..6 to receivers 7..13
      begin
         logic [N*AW-1:0] d;
         d = '0;
         for (int k = 0; k < 7; k++) d |= dp(k, k + 7);
         step(14'h007F, d, '0);
      end
      check("R5 seven links", 64'(enc_en), 64'h007F);
      for (int k = 0; k < 7; k++) check("R6 ascending codes", 64'(ecode(k)), 64'(k));
      begin
         logic [N*AW-1:0] d;
         d = '0;
         for (int k = 7; k < 14; k++) d |= dp(k, k - 7);
         step(14'h3F80, d, '0);
      end
      check("R5 pool exhausted", 64'(enc_en), 64'h007F);
      step('0, '0, 14'h0008);
      check("R7 code3 freed", 64'(enc_en), 64'h0077);
      check("R7 rx10 freed", 64'(dec_grant[10]), 64'(0));
      step(14'h0300, dp(8, 0) | dp(9, 1), '0);
      check("R5 one code one grant", 64'(enc_en), 64'h0177);
      check("R6 middle code reissued", 64'(ecode(8)), 64'(3));
      check("R10 rx0 code", 64'(dcode(0)), 64'(3));

      rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid-run reset", 64'(enc_en | dec_grant), 64'(0));
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule